// File: doc/BRIEF.md
# Auto-Incrementing Parameter RAM Port

This block owns a small parameter memory and gives a host access to all of it through two registers: a control word and a data word. The host writes the control word once to set a start location, a transfer direction, whether that location is loaded into the internal pointer, and whether the pointer steps after each access. It then streams a run of consecutive words by reading or writing the data word over and over. The port and the host bus share one clock, so a host can issue data accesses on consecutive cycles without polling.

Reads are prefetched. A read-direction control write copies the word at the start location into the data register in the following cycle. Each data read hands out the word already held and at the same time fetches the word at the stepped pointer. A second, independent, registered read port lets the processing datapath fetch coefficients while the host streams updates. The stored word width is a parameter. A wide instance holds gain coefficients. A 5-bit instance holds shift amounts, keeps only the low bits of each written word and returns them zero-extended.

Top module: `param_ram_port`

## Requirements
- R1: After reset the control register reads back 0x00004000. A control write is read back unchanged at host register select 0.
- R2: The control word holds the start location in bits 11:0, sequential stepping in bit 12, pointer load in bit 13 and direction in bit 14 (1 = host writes, 0 = host reads). A control write with bit 13 set loads the pointer from bits 11:0. With bit 13 clear the pointer keeps its value.
- R3: In write direction with stepping on, each data write stores the word at the pointer and then advances the pointer by one.
- R4: In read direction with stepping on, each data read returns the word at the pointer and advances the pointer. Back-to-back reads on consecutive cycles return consecutive words.
- R5: host_busy is high for exactly the one cycle after a read-direction control write. After that cycle the data register holds the word at the start location. A data read made while busy has no effect.
- R6: With stepping off, data accesses use the pointer without moving it. Repeated writes overwrite one location, and repeated reads return one word.
- R7: The pointer wraps from the last location to location 0. A start field at or beyond the depth loads 0.
- R8: Only data reads in read direction move the pointer on the read side. Control reads, data reads in write direction, and data writes in read direction change neither memory nor pointer.
- R9: With a storage width below the bus width, only the low bits of a written word are kept, and every read returns them zero-extended.
- R10: The datapath port returns the word at dp_addr one cycle after the address is presented. If a host write hits the same location in the same cycle, the datapath sees the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by host and datapath |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access valid this cycle |
| host_wr | input | 1 | 1 = host write, 0 = host read |
| host_reg | input | 1 | 0 = control register, 1 = data register |
| host_wdata | input | BUS_W | Host write data |
| host_rdata | output | BUS_W | Selected register contents, combinational |
| host_busy | output | 1 | Prefetch after a read-direction control write in progress |
| dp_addr | input | $clog2(DEPTH) | Datapath read location |
| dp_rdata | output | BUS_W | Datapath read word, registered, zero-extended |

## Verification
The bench targets the points where a streaming port usually slips. It checks the wrap from the last location to zero, which a design that saturates or overruns would write into the wrong word. It checks that a pointer stays put when stepping is off or when the access is in the wrong direction; a design that stepped anyway would shift every later word by one. It checks back-to-back reads right after the one-cycle prefetch, where a stale data register would repeat or skip a word. It also checks a host write colliding with a datapath read, and truncation in the 5-bit instance, which would leak upper bits if the store were too wide.

// File: rtl/pram_pkg.sv
package pram_pkg;

  localparam int unsigned FLD_ADDR_W = 12;
  localparam int unsigned POS_SEQ    = 12;
  localparam int unsigned POS_INIT   = 13;
  localparam int unsigned POS_DIR    = 14;
  localparam logic [31:0] CTRL_RST   = 32'h0000_4000;

  typedef struct packed {
    logic                  dir_wr;
    logic                  init;
    logic                  seq;
    logic [FLD_ADDR_W-1:0] start;
  } ctrl_fields_t;

  function automatic ctrl_fields_t split_ctrl(input logic [31:0] w);
    ctrl_fields_t f;
    f.dir_wr = w[POS_DIR];
    f.init   = w[POS_INIT];
    f.seq    = w[POS_SEQ];
    f.start  = w[FLD_ADDR_W-1:0];
    return f;
  endfunction

  // next location after p, wrapping at depth
  function automatic int unsigned bump(input int unsigned p, input int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // start location taken from the control field, out-of-range folds to 0
  function automatic int unsigned fold_start(input int unsigned a, input int unsigned depth);
    return (a >= depth) ? 0 : a;
  endfunction

endpackage

// File: rtl/pram_ctrl_reg.sv
module pram_ctrl_reg
  import pram_pkg::*;
#(
  parameter int unsigned BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] ctrl_q,
  output ctrl_fields_t     fields
);

  always_ff @(posedge clk) begin
    if (!rst_n)  ctrl_q <= CTRL_RST[BUS_W-1:0];
    else if (we) ctrl_q <= wdata;
  end

  assign fields = split_ctrl(32'(ctrl_q));

  AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ctrl_q)); // R1

  AST_CTRL_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ctrl_q == $past(wdata))); // R1

endmodule

// File: rtl/pram_pointer.sv
module pram_pointer
  import pram_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FLD_ADDR_W-1:0] load_val,
  input  logic                  step,
  output logic [ADDR_W-1:0]     ptr,
  output logic [ADDR_W-1:0]     ptr_inc
);

  logic [ADDR_W-1:0] load_ptr;

  assign ptr_inc  = ADDR_W'(bump(32'(ptr), DEPTH));
  assign load_ptr = ADDR_W'(fold_start(32'(load_val), DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n)     ptr <= '0;
    else if (load)  ptr <= load_ptr;
    else if (step)  ptr <= ptr_inc;
  end

  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ptr) < DEPTH); // R7

  AST_PTR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(ptr)); // R6

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && 32'(ptr) == DEPTH - 1) |=> (ptr == '0)); // R7

endmodule

// File: rtl/pram_store.sv
module pram_store #(
  parameter int unsigned STORE_W = 32,
  parameter int unsigned BUS_W   = 32,
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] pf_addr,
  output logic [BUS_W-1:0]  pf_word,
  input  logic [ADDR_W-1:0] dp_addr,
  output logic [BUS_W-1:0]  dp_rdata
);

  logic [STORE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data[STORE_W-1:0];
  end

  // datapath port samples the array before this edge's write lands
  always_ff @(posedge clk) begin
    if (!rst_n) dp_rdata <= '0;
    else        dp_rdata <= BUS_W'(mem[dp_addr]);
  end

  assign pf_word = BUS_W'(mem[pf_addr]);

  generate
    if (STORE_W < BUS_W) begin : g_narrow
      AST_DP_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        dp_rdata[BUS_W-1:STORE_W] == '0); // R9
      AST_PF_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        pf_word[BUS_W-1:STORE_W] == '0); // R9
    end
  endgenerate

endmodule

// File: rtl/param_ram_port.sv
module param_ram_port
  import pram_pkg::*;
#(
  parameter int unsigned BUS_W   = 32,
  parameter int unsigned STORE_W = 32,
  parameter int unsigned DEPTH   = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_sel,
  input  logic                     host_wr,
  input  logic                     host_reg,
  input  logic [BUS_W-1:0]         host_wdata,
  output logic [BUS_W-1:0]         host_rdata,
  output logic                     host_busy,
  input  logic [$clog2(DEPTH)-1:0] dp_addr,
  output logic [BUS_W-1:0]         dp_rdata
);

  localparam int unsigned ADDR_W = $clog2(DEPTH);

  ctrl_fields_t      fields;
  logic [BUS_W-1:0]  ctrl_q;
  logic [BUS_W-1:0]  data_q;
  logic [BUS_W-1:0]  pf_word;
  logic [ADDR_W-1:0] ptr, ptr_inc, pf_addr;
  logic              pf_pend;

  // named access events
  logic ev_ctrl_wr, ev_data_wr, ev_data_rd, ev_step, ev_rdcfg;

  assign ev_ctrl_wr = host_sel &  host_wr & ~host_reg;
  assign ev_data_wr = host_sel &  host_wr &  host_reg &  fields.dir_wr;
  assign ev_data_rd = host_sel & ~host_wr &  host_reg & ~fields.dir_wr & ~pf_pend;
  assign ev_step    = (ev_data_wr | ev_data_rd) & fields.seq;
  assign ev_rdcfg   = ev_ctrl_wr & ~host_wdata[POS_DIR];

  pram_ctrl_reg #(.BUS_W(BUS_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (ev_ctrl_wr),
    .wdata  (host_wdata),
    .ctrl_q (ctrl_q),
    .fields (fields)
  );

  pram_pointer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_ctrl_wr & host_wdata[POS_INIT]),
    .load_val (host_wdata[FLD_ADDR_W-1:0]),
    .step     (ev_step),
    .ptr      (ptr),
    .ptr_inc  (ptr_inc)
  );

  // prefetch source: current word after a control write, else the word the
  // pointer moves to on this read
  assign pf_addr = (pf_pend || !fields.seq) ? ptr : ptr_inc;

  pram_store #(.STORE_W(STORE_W), .BUS_W(BUS_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ev_data_wr),
    .wr_addr  (ptr),
    .wr_data  (host_wdata),
    .pf_addr  (pf_addr),
    .pf_word  (pf_word),
    .dp_addr  (dp_addr),
    .dp_rdata (dp_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_pend <= 1'b0;
      data_q  <= '0;
    end else begin
      pf_pend <= ev_rdcfg;
      if (pf_pend || ev_data_rd) data_q <= pf_word;
    end
  end

  assign host_busy  = pf_pend;
  assign host_rdata = host_reg ? data_q : ctrl_q;

  AST_BUSY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    host_busy |=> !host_busy); // R5

  AST_BUSY_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rdcfg |=> host_busy); // R5

  AST_WRONG_DIR_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && host_wr && host_reg && !fields.dir_wr) |=> $stable(ptr)); // R8

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_data_rd && !host_busy) |=> $stable(data_q)); // R8

endmodule

// File: tb/param_ram_port_test.sv
module param_ram_port_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_m = 1'b0, sel_s = 1'b0;
  logic        hwr = 1'b0, hreg = 1'b0;
  logic [31:0] hwd = '0;
  logic [31:0] rdata_m, rdata_s, dpd_m, dpd_s;
  logic        busy_m, busy_s;
  logic [5:0]  dpa_m = '0;
  logic [3:0]  dpa_s = '0;

  logic [31:0] rd_m, rd_s;
  logic        bsy_m;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  param_ram_port uut (
    .clk(clk), .rst_n(rst_n), .host_sel(sel_m), .host_wr(hwr), .host_reg(hreg),
    .host_wdata(hwd), .host_rdata(rdata_m), .host_busy(busy_m),
    .dp_addr(dpa_m), .dp_rdata(dpd_m)
  );

  param_ram_port #(.STORE_W(5), .DEPTH(16)) uut_shift (
    .clk(clk), .rst_n(rst_n), .host_sel(sel_s), .host_wr(hwr), .host_reg(hreg),
    .host_wdata(hwd), .host_rdata(rdata_s), .host_busy(busy_s),
    .dp_addr(dpa_s), .dp_rdata(dpd_s)
  );

  // op: 0 idle, 1 control write, 2 data write, 3 data read (val = expected)
  localparam logic [33:0] VEC [16] = '{
    {2'd1, 32'h0000_7005},  // write dir, load, step, start 5
    {2'd2, 32'h1111_1111},  // R3 -> loc 5
    {2'd2, 32'hA5A5_0001},  // R3 -> loc 6
    {2'd2, 32'hDEAD_BEEF},  // R3 -> loc 7
    {2'd1, 32'h0000_3005},  // read dir, load, step, start 5
    {2'd0, 32'h0},
    {2'd3, 32'h1111_1111},  // R4
    {2'd3, 32'hA5A5_0001},  // R4
    {2'd3, 32'hDEAD_BEEF},  // R4
    {2'd1, 32'h0000_703F},  // write dir at last location
    {2'd2, 32'h0000_0063},  // loc 63
    {2'd2, 32'h0000_0100},  // R7 wraps to loc 0
    {2'd1, 32'h0000_303F},
    {2'd0, 32'h0},
    {2'd3, 32'h0000_0063},
    {2'd3, 32'h0000_0100}   // R7
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit shp, input logic s, input logic w, input logic r,
                     input logic [31:0] d);
    @(negedge clk);
    sel_m = shp ? 1'b0 : s;
    sel_s = shp ? s : 1'b0;
    hwr = w; hreg = r; hwd = d;
    #1;
    rd_m = rdata_m; rd_s = rdata_s; bsy_m = busy_m;
    @(posedge clk);
  endtask

  task automatic idle();
    acc(1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // reset state
    idle();
    chk("R1 reset control value", rd_m, 32'h0000_4000);
    chk("R5 busy low after reset", {31'b0, bsy_m}, 32'h0);

    // vector table walk
    for (int i = 0; i < 16; i++) begin
      case (VEC[i][33:32])
        2'd1: acc(1'b0, 1'b1, 1'b1, 1'b0, VEC[i][31:0]);
        2'd2: acc(1'b0, 1'b1, 1'b1, 1'b1, VEC[i][31:0]);
        2'd3: begin
          acc(1'b0, 1'b1, 1'b0, 1'b1, 32'h0);
          chk($sformatf("R3/R4/R7 table step %0d", i), rd_m, VEC[i][31:0]);
        end
        default: idle();
      endcase
    end
    idle();

    // R1 readback, R2 load vs no-load
    acc(1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_700A);
    acc(1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_AAAA);   // loc 10
    acc(1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_5014);   // no load, start 20 ignored
    acc(1'b0, 1'b1, 1'b0, 1'b0, 32'h0);
    chk("R1 control readback", rd_m, 32'h0000_5014);
    acc(1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_BBBB);   // R2 expects loc 11
    acc(1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_300A);
    idle();
    acc(1'b0, 1'b1, 1'b0, 1'b1, 32'h0);
    chk("R2 loaded start", rd_m, 32'h0000_AAAA);
    acc(1'b0, 1'b1, 1'b0, 1'b1, 32'h0);
    chk("R2 pointer kept without load", rd_m, 32'h0000_BBBB);
    idle();

    // R5 busy pulse and prefetch
    acc(1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_3005);
    idle();
    chk("R5 busy in prefetch cycle", {31'b0, bsy_m}, 32'h1);
    idle();
    chk("R5 busy drops", {31'b0, bsy_m}, 32'h0);
    acc(1'b0, 1'b1, 1'b0, 1'b1, 32'h0);
    chk("R5 prefetched start word", rd_m, 32'h1111_1111);
    // read during busy is ignored
    acc(1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_3006);
    acc(1'b0, 1'b1, 1'b0, 1'b1, 32'h0);
    acc(1'b0, 1'b1, 1'b0, 1'b1, 32'h0);
    chk("R5 read during busy does not step", rd_m, 32'hA5A5_0001);
    idle();

    // R6 stepping off
    acc(1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_7014);
    acc(1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0C0C);   // loc 20
    acc(1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0D0D);   // loc 21
    acc(1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_6014);   // no step
    acc(1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0A0A);
    acc(1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0B0B);
    acc(1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_2014);
    idle();
    acc(1'b0, 1'b1, 1'b0, 1'b1, 32'h0);
    chk("R6 last write kept", rd_m, 32'h0000_0B0B);
    acc(1'b0, 1'b1, 1'b0, 1'b1, 32'h0);
    chk("R6 read without step repeats", rd_m, 32'h0000_0B0B);
    acc(1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_3015);
    idle();
    acc(1'b0, 1'b1, 1'b0, 1'b1, 32'h0);
    chk("R6 neighbour untouched", rd_m, 32'h0000_0D0D);
    idle();

    // R8 accesses that must not move anything
    acc(1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_701E);
    acc(1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_00E0);   // loc 30
    acc(1'b0, 1'b1, 1'b0, 1'b1, 32'h0);           // data read, write dir
    acc(1'b0, 1'b1, 1'b0, 1'b0, 32'h0);           // control read
    acc(1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_00F1);   // loc 31
    acc(1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_301E);
    idle();
    acc(1'b0, 1'b1, 1'b0, 1'b1, 32'h0);
    chk("R8 first word", rd_m, 32'h0000_00E0);
    acc(1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0666);   // write in read dir
    acc(1'b0, 1'b1, 1'b0, 1'b1, 32'h0);
    chk("R8 wrong-dir reads/writes ignored", rd_m, 32'h0000_00F1);
    acc(1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_301F);
    idle();
    acc(1'b0, 1'b1, 1'b0, 1'b1, 32'h0);
    chk("R8 memory not written in read dir", rd_m, 32'h0000_00F1);
    idle();

    // R7 out-of-range start folds to 0
    acc(1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_3050);
    idle();
    acc(1'b0, 1'b1, 1'b0, 1'b1, 32'h0);
    chk("R7 start beyond depth loads 0", rd_m, 32'h0000_0100);
    idle();

    // R10 datapath port
    @(negedge clk); dpa_m = 6'd5;
    @(posedge clk); @(negedge clk); #1;
    chk("R10 datapath read", dpd_m, 32'h1111_1111);
    acc(1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_7028);
    acc(1'b0, 1'b1, 1'b1, 1'b1, 32'h1234_5678);   // loc 40
    acc(1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_7028);
    @(negedge clk);
    dpa_m = 6'd40; sel_m = 1'b1; hwr = 1'b1; hreg = 1'b1; hwd = 32'h8765_4321;
    @(posedge clk); @(negedge clk);
    sel_m = 1'b0; #1;
    chk("R10 collision returns old word", dpd_m, 32'h1234_5678);
    @(posedge clk); @(negedge clk); #1;
    chk("R10 new word next cycle", dpd_m, 32'h8765_4321);

    // R9 narrow instance
    acc(1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_7002);
    acc(1'b1, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFE7);
    acc(1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0020);
    acc(1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_3002);
    acc(1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    acc(1'b1, 1'b1, 1'b0, 1'b1, 32'h0);
    chk("R9 low bits kept, zero-extended", rd_s, 32'h0000_0007);
    acc(1'b1, 1'b1, 1'b0, 1'b1, 32'h0);
    chk("R9 bit above width dropped", rd_s, 32'h0000_0000);
    @(negedge clk); sel_s = 1'b0; dpa_s = 4'd2;
    @(posedge clk); @(negedge clk); #1;
    chk("R9 datapath zero-extended", dpd_s, 32'h0000_0007);

    finish_run();
  end

endmodule